// File: doc/BRIEF.md
# Partial-Array Refresh Address Sequencer

This block produces the row addresses for the self-refresh of a pseudo-static memory holding 1M words of 16 bits. The word address is 20 bits wide and the low 7 bits select a column. The upper 13 bits therefore name one of 8192 rows, and each refresh covers one row. A 3-bit selector limits refresh to part of the array: the whole array, or one half, one quarter or one eighth of it, or nothing at all. A partial window sits either at the bottom or at the top of the row space.

Each periodic tick asks for one refresh. If no request is already open, the block raises a request that carries the current row. The memory core accepts the request with an acknowledge. The row counter then advances, and after the last row of the window it returns to the first row. The window in use is the one the selector showed at the previous accepted tick. If the selector has changed since then, the next tick restarts the counter at the start of the new window. A refresh-enable input from power-down control stops all activity while it is low.

Top module: `par_refresh_seq`

## Requirements
- R1: After reset `refresh_req` is low, `refresh_row` is 0, and the window in use is the full array (selector 000).
- R2: Selector codes map to bottom-anchored row windows as follows. 000 gives rows 0–8191 (words 00000h–FFFFFh). 001 gives rows 0–4095 (words 00000h–7FFFFh). 010 gives rows 0–2047 (words 00000h–3FFFFh). 011 gives rows 0–1023 (words 00000h–1FFFFh).
- R3: Selector codes map to top-anchored row windows as follows. 101 gives rows 4096–8191 (words 80000h–FFFFFh). 110 gives rows 6144–8191 (words C0000h–FFFFFh). 111 gives rows 7168–8191 (words E0000h–FFFFFh).
- R4: Selector 100 selects no rows. A tick that arrives while it is applied raises no request and leaves the row counter unchanged.
- R5: A tick sampled while enable is high, the selector is not 100 and no request is open raises `refresh_req` on the next cycle. `refresh_row` then holds steady until the acknowledge.
- R6: An acknowledge sampled while `refresh_req` is high closes the request on the next cycle. It also moves `refresh_row` to the next row, and from the last row of the window back to its first row.
- R7: If the selector differs from the one used at the last accepted tick, the next accepted tick loads the first row of the new window before raising the request.
- R8: While enable is low, `refresh_req` is low in that same cycle, any open request is dropped without advancing the row, and ticks are ignored.
- R9: A tick that arrives while a request is open is dropped. An acknowledge sampled while `refresh_req` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_en | input | 1 | Refresh enable from power-down control; low stops all refresh activity |
| refresh_tick | input | 1 | One-cycle periodic refresh pulse |
| par_sel | input | 3 | Array portion selector (codes in R2–R4) |
| refresh_ack | input | 1 | Memory core accepts the open request |
| refresh_req | output | 1 | Refresh request for `refresh_row` |
| refresh_row | output | 13 | Row address to refresh (word address bits 19:7) |

## Verification
The checker assumes that `refresh_ack` only matters while `refresh_req` is visible, and that ticks and acknowledges are single-cycle levels that are sampled at the clock edge. It also assumes the selector may change in any cycle, including while a request is open. The random stimulus follows these rules. Ticks, acknowledges and enable drops are drawn independently, so acknowledges and ticks often land on idle or pending cycles. The selector changes only rarely, so that the counter runs through stretches of its windows. The directed sweeps walk every non-empty window through one complete wrap.

// File: rtl/par_pkg.sv
package par_pkg;

    // Selector codes for the refreshed portion of the array.
    // Bit 2 picks the top anchor, bits 1:0 give the halving count.
    typedef enum logic [2:0] {
        PAR_FULL     = 3'b000,
        PAR_BOT_HALF = 3'b001,
        PAR_BOT_QTR  = 3'b010,
        PAR_BOT_8TH  = 3'b011,
        PAR_NONE     = 3'b100,
        PAR_TOP_HALF = 3'b101,
        PAR_TOP_QTR  = 3'b110,
        PAR_TOP_8TH  = 3'b111
    } par_sel_e;

    function automatic logic par_is_top(input logic [2:0] sel);
        return sel[2];
    endfunction

    function automatic logic [1:0] par_halvings(input logic [2:0] sel);
        return sel[1:0];
    endfunction

endpackage

// File: rtl/par_window_decode.sv
module par_window_decode
    import par_pkg::*;
#(
    parameter int ROW_W = 13
) (
    input  logic [2:0]       sel,
    output logic             active,
    output logic [ROW_W-1:0] first_row,
    output logic [ROW_W-1:0] last_row
);

    logic [ROW_W-1:0] span_mask;

    // Window size minus one is an all-ones mask shifted by the halving count;
    // the top anchor is its complement, the last row is the OR of both.
    always_comb begin
        span_mask = {ROW_W{1'b1}} >> par_halvings(sel);
        active    = (sel != PAR_NONE);
        first_row = par_is_top(sel) ? ~span_mask : '0;
        last_row  = first_row | span_mask;
    end

endmodule

// File: rtl/par_row_step.sv
module par_row_step #(
    parameter int ROW_W = 13
) (
    input  logic [ROW_W-1:0] row,
    input  logic [ROW_W-1:0] first_row,
    input  logic [ROW_W-1:0] last_row,
    output logic [ROW_W-1:0] next_row
);

    always_comb begin
        if (row == last_row) begin
            next_row = first_row;
        end else begin
            next_row = row + 1'b1;
        end
    end

endmodule

// File: rtl/par_refresh_seq.sv
module par_refresh_seq
    import par_pkg::*;
#(
    parameter int WORD_AW = 20,
    parameter int COL_W   = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     refresh_en,
    input  logic                     refresh_tick,
    input  logic [2:0]               par_sel,
    input  logic                     refresh_ack,
    output logic                     refresh_req,
    output logic [WORD_AW-COL_W-1:0] refresh_row
);

    localparam int ROW_W = WORD_AW - COL_W;

    typedef struct packed {
        logic             pend;
        logic [ROW_W-1:0] row;
        logic [2:0]       applied;
    } seq_state_t;

    seq_state_t st_d;
    seq_state_t st_q;

    // Window requested by the live selector (used for reload)
    logic             live_active;
    logic [ROW_W-1:0] live_first;
    logic [ROW_W-1:0] live_last;

    // Window currently in use (used for wrap)
    logic             used_active;
    logic [ROW_W-1:0] used_first;
    logic [ROW_W-1:0] used_last;
    logic [ROW_W-1:0] step_row;

    par_window_decode #(.ROW_W(ROW_W)) u_live_win (
        .sel       (par_sel),
        .active    (live_active),
        .first_row (live_first),
        .last_row  (live_last)
    );

    par_window_decode #(.ROW_W(ROW_W)) u_used_win (
        .sel       (st_q.applied),
        .active    (used_active),
        .first_row (used_first),
        .last_row  (used_last)
    );

    par_row_step #(.ROW_W(ROW_W)) u_step (
        .row       (st_q.row),
        .first_row (used_first),
        .last_row  (used_last),
        .next_row  (step_row)
    );

    always_comb begin
        st_d = st_q;
        if (!refresh_en) begin
            // power-down: drop any open request, keep the row
            st_d.pend = 1'b0;
        end else if (st_q.pend) begin
            if (refresh_ack && used_active) begin
                st_d.pend = 1'b0;
                st_d.row  = step_row;
            end
        end else if (refresh_tick && live_active) begin
            st_d.pend    = 1'b1;
            st_d.applied = par_sel;
            if (par_sel != st_q.applied) begin
                st_d.row = live_first;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend    <= 1'b0;
            st_q.row     <= '0;
            st_q.applied <= PAR_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign refresh_req = st_q.pend & refresh_en;
    assign refresh_row = st_q.row;

    // live_last is only needed for symmetry of the decoder outputs
    logic unused_live_last;
    assign unused_live_last = ^live_last;

endmodule

// File: rtl/par_refresh_seq_chk.sv
module par_refresh_seq_chk #(
    parameter int RW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          refresh_en,
    input logic          refresh_tick,
    input logic [2:0]    par_sel,
    input logic          refresh_ack,
    input logic          refresh_req,
    input logic [RW-1:0] refresh_row
);

    assert_no_req_when_disabled_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        !refresh_en |-> !refresh_req
    );

    assert_row_held_open_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        (refresh_req && !refresh_ack) |=> $stable(refresh_row)
    );

    assert_req_follows_tick_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(refresh_req) |-> $past(refresh_tick)
    );

    assert_empty_window_quiet_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (par_sel == 3'b100 && !refresh_req) |=> !refresh_req
    );

    assert_ack_closes_req_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        (refresh_req && refresh_ack) |=> !refresh_req
    );

    assert_idle_row_steady_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!refresh_req && !refresh_tick) |=> $stable(refresh_row)
    );

endmodule

bind par_refresh_seq par_refresh_seq_chk #(.RW(WORD_AW - COL_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .refresh_en   (refresh_en),
    .refresh_tick (refresh_tick),
    .par_sel      (par_sel),
    .refresh_ack  (refresh_ack),
    .refresh_req  (refresh_req),
    .refresh_row  (refresh_row)
);

// File: tb/par_refresh_seq_test.sv
module par_refresh_seq_test;

    localparam int WORD_AW = 20;
    localparam int COL_W   = 7;
    localparam int ROW_W   = WORD_AW - COL_W;
    localparam int NROWS   = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0;
    logic             tick = 1'b0;
    logic             ack = 1'b0;
    logic [2:0]       sel = 3'b000;
    logic             req;
    logic [ROW_W-1:0] row;

    int total = 0;
    int bad   = 0;

    bit         m_pend = 1'b0;
    int         m_row  = 0;
    logic [2:0] m_app  = 3'b000;

    always #2 clk = ~clk;

    par_refresh_seq #(.WORD_AW(WORD_AW), .COL_W(COL_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .refresh_en   (en),
        .refresh_tick (tick),
        .par_sel      (sel),
        .refresh_ack  (ack),
        .refresh_req  (req),
        .refresh_row  (row)
    );

    function automatic int win_first(input logic [2:0] f);
        case (f)
            3'd5:    return NROWS / 2;
            3'd6:    return (NROWS / 4) * 3;
            3'd7:    return (NROWS / 8) * 7;
            default: return 0;
        endcase
    endfunction

    function automatic int win_last(input logic [2:0] f);
        case (f)
            3'd1:    return NROWS / 2 - 1;
            3'd2:    return NROWS / 4 - 1;
            3'd3:    return NROWS / 8 - 1;
            3'd4:    return 0;
            default: return NROWS - 1;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, update the model, sample after the rising edge.
    task automatic drive(input bit t, input bit a, input bit e, input logic [2:0] f);
        string qtag = "R5";
        string rtag = "R5";
        bit    exp_req;
        @(negedge clk);
        tick = t; ack = a; en = e; sel = f;
        if (!e) begin
            m_pend = 1'b0;
            qtag = "R8"; rtag = "R8";
        end else if (m_pend) begin
            if (a) begin
                m_pend = 1'b0;
                m_row  = (m_row == win_last(m_app)) ? win_first(m_app) : m_row + 1;
                qtag = "R6"; rtag = "R6";
            end else if (t) begin
                qtag = "R9";
            end
        end else if (t && f != 3'd4) begin
            m_pend = 1'b1;
            if (f != m_app) begin
                m_row = win_first(f);
                rtag  = "R7";
            end
            m_app = f;
        end else if (f == 3'd4) begin
            qtag = "R4"; rtag = "R4";
        end else if (a) begin
            qtag = "R9"; rtag = "R9";
        end
        exp_req = m_pend && e;
        @(posedge clk);
        #1;
        check(req === exp_req, qtag, int'(req), int'(exp_req));
        check(int'(row) == m_row, rtag, int'(row), m_row);
    endtask

    task automatic sweep(input logic [2:0] f, input string tag);
        int w_first = win_first(f);
        int w_last  = win_last(f);
        int span    = w_last - w_first + 1;
        for (int i = 0; i <= span; i++) begin
            drive(1'b1, 1'b0, 1'b1, f);
            if (i == 0)        check(int'(row) == w_first, tag, int'(row), w_first);
            if (i == span - 1) check(int'(row) == w_last, tag, int'(row), w_last);
            if (i == span)     check(int'(row) == w_first, "R6", int'(row), w_first);
            drive(1'b0, 1'b1, 1'b1, f);
        end
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(req === 1'b0, "R1", int'(req), 0);
        check(row == '0, "R1", int'(row), 0);
        @(negedge clk);
        rst_n = 1'b1;
        en    = 1'b1;
        drive(1'b0, 1'b0, 1'b1, 3'd0);
        check(req === 1'b0 && row == '0, "R1", int'(row), 0);

        // R2 / R3 / R6 / R7: full wrap through every non-empty window
        sweep(3'd0, "R2");
        sweep(3'd1, "R2");
        sweep(3'd2, "R2");
        sweep(3'd3, "R2");
        sweep(3'd5, "R3");
        sweep(3'd6, "R3");
        sweep(3'd7, "R3");

        // R4: empty selection issues nothing and keeps the counter
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 1'b0, 1'b1, 3'd4);
            check(req === 1'b0, "R4", int'(req), 0);
        end
        drive(1'b1, 1'b0, 1'b1, 3'd7);
        check(int'(row) == 7169, "R4", int'(row), 7169);

        // R8: enable low drops the open request without advancing
        drive(1'b0, 1'b1, 1'b0, 3'd7);
        check(req === 1'b0, "R8", int'(req), 0);
        drive(1'b1, 1'b0, 1'b0, 3'd7);
        check(req === 1'b0 && int'(row) == 7169, "R8", int'(row), 7169);
        drive(1'b1, 1'b0, 1'b1, 3'd7);
        check(req === 1'b1 && int'(row) == 7169, "R8", int'(row), 7169);
        drive(1'b0, 1'b1, 1'b1, 3'd7);

        // R9: stray acknowledge and tick while pending
        drive(1'b0, 1'b1, 1'b1, 3'd7);
        check(int'(row) == 7170, "R9", int'(row), 7170);
        drive(1'b1, 1'b0, 1'b1, 3'd7);
        drive(1'b1, 1'b0, 1'b1, 3'd7);
        drive(1'b0, 1'b1, 1'b1, 3'd7);
        check(int'(row) == 7171, "R9", int'(row), 7171);
        drive(1'b0, 1'b0, 1'b1, 3'd7);
        check(req === 1'b0, "R9", int'(req), 0);

        // R7: change of selector reloads on the next tick
        drive(1'b1, 1'b0, 1'b1, 3'd2);
        check(req === 1'b1 && row == '0, "R7", int'(row), 0);
        drive(1'b0, 1'b1, 1'b1, 3'd2);

        // Constrained random mix
        begin
            logic [2:0] rs;
            int seed_dummy;
            seed_dummy = $urandom(32'h5eed_1234);
            rs = 3'd3;
            for (int i = 0; i < 20000; i++) begin
                bit rt, ra, re;
                if ($urandom_range(99) == 0) rs = 3'($urandom_range(7));
                rt = ($urandom_range(99) < 30);
                ra = ($urandom_range(99) < 40);
                re = ($urandom_range(99) < 92);
                drive(rt, ra, re, rs);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule